// File: doc/BRIEF.md
# Variable-Length Instruction Parcel Assembler

This block turns a stream of 16-bit instruction parcels into whole instructions of varying length. The first parcel of each instruction carries a prefix code in its low bits. The block decodes that code to find how many parcels the instruction spans, gathers that many parcels, and then offers the assembled instruction on its output stream together with its length in parcels. Both sides use a valid/ready handshake. The parcel that follows the last parcel of an instruction always starts the next instruction, so an instruction may begin on any 16-bit boundary.

The first parcel fills bits [15:0] of the 176-bit output field, and each later parcel fills the next-higher 16 bits. Bits above the instruction's length are zero. A first parcel that carries the reserved long-instruction code is not assembled. It is passed out alone, with length 1 and the error flag set, and length detection restarts on the parcel after it. A synchronous flush drops any partly gathered or held instruction.

The controller has three states. `ST_IDLE` waits for a first parcel. `ST_COLLECT` gathers the remaining parcels. `ST_HOLD` presents a finished instruction. The transitions are:
- IDLE→HOLD when the accepted first parcel is a one-parcel or reserved code.
- IDLE→COLLECT when the accepted first parcel announces two or more parcels.
- COLLECT→HOLD when the last parcel is accepted.
- HOLD→IDLE when the output is taken.
- Any state goes to IDLE when flush is high.

Top module: `parcel_assembler`

## Requirements
- R1: A first parcel whose bits [1:0] are not 2'b11 gives a one-parcel instruction (out_len = 1, out_rsvd = 0).
- R2: A first parcel with bits [1:0] = 2'b11 and bits [4:2] not equal to 3'b111 gives a two-parcel instruction.
- R3: A first parcel whose bits [5:0] are 6'b011111 gives a three-parcel instruction.
- R4: A first parcel whose bits [6:0] are 7'b0111111 gives a four-parcel instruction.
- R5: A first parcel whose bits [6:0] are 7'b1111111 and whose field k = bits [14:12] is not 3'b111 gives an instruction of 5 + k parcels (5 to 11).
- R6: A first parcel whose bits [6:0] are 7'b1111111 and whose bits [14:12] are 3'b111 is presented alone, with out_len = 1 and out_rsvd = 1, and the next parcel is decoded as a first parcel.
- R7: Parcel j of an instruction (j = 0 for the first parcel) appears in out_instr[16*j+15 : 16*j].
- R8: Every parcel accepted on the input belongs to exactly one output instruction, and the parcel after an instruction's last parcel starts the next instruction.
- R9: Bits of out_instr at and above 16*out_len are zero while out_valid is high.
- R10: While out_valid is high, in_ready is low. While out_valid is high and out_ready is low, out_instr, out_len and out_rsvd hold their values.
- R11: When flush is high, in_ready is low. In the following cycle out_valid is low and the block waits for a first parcel, and no parcel of the dropped instruction appears in any later output.
- R12: During reset and after reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous drop of any partial or held instruction |
| in_valid | input | 1 | Parcel offered |
| in_ready | output | 1 | Parcel accepted when in_valid is also high |
| in_parcel | input | 16 | Incoming parcel, in increasing address order |
| out_valid | output | 1 | Assembled instruction available |
| out_ready | input | 1 | Consumer takes the instruction |
| out_instr | output | 176 | Assembled instruction, first parcel in the low bits |
| out_len | output | 4 | Instruction length in parcels (1 to 11) |
| out_rsvd | output | 1 | Reserved-encoding flag |

## Verification
An instruction of n parcels raises out_valid in the cycle after its n-th parcel is accepted, because the parcel store and the state are one register stage. An instruction that is taken leaves out_valid low for one cycle before the next instruction can start. in_ready depends only on the state and on flush, so it changes in the cycle after an edge or at once with flush. The bench sets all inputs on the falling edge. It reads the outputs shortly after that and decides from those values which handshakes will complete at the next rising edge. Each output is therefore compared with the expected instruction in the very cycle in which it is taken.

// File: rtl/parcel_pkg.sv
package parcel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_HOLD    = 2'd2
    } asm_state_e;

endpackage

// File: rtl/parcel_len_decode.sv
module parcel_len_decode #(
    parameter int PARCEL_W = 16,
    parameter int LEN_W    = 4
) (
    input  logic [PARCEL_W-1:0] head,
    output logic [LEN_W-1:0]    len,
    output logic                rsvd
);

    // Prefix code of the first parcel, tested from the shortest form upward.
    always_comb begin
        rsvd = 1'b0;
        if (head[1:0] != 2'b11) begin
            len = LEN_W'(1);
        end else if (head[4:2] != 3'b111) begin
            len = LEN_W'(2);
        end else if (head[5] == 1'b0) begin
            len = LEN_W'(3);
        end else if (head[6] == 1'b0) begin
            len = LEN_W'(4);
        end else if (head[14:12] != 3'b111) begin
            len = LEN_W'(5) + LEN_W'(head[14:12]);
        end else begin
            // Long reserved code: pass the parcel through alone.
            len  = LEN_W'(1);
            rsvd = 1'b1;
        end
    end

endmodule

// File: rtl/parcel_slot_bank.sv
module parcel_slot_bank #(
    parameter int PARCEL_W = 16,
    parameter int SLOTS    = 11,
    parameter int IDX_W    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [PARCEL_W-1:0]       wr_data,
    output logic [PARCEL_W*SLOTS-1:0] image
);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [PARCEL_W-1:0] slot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (start) begin
                // A new instruction writes slot 0 and clears every higher slot.
                slot_q <= (g == 0) ? wr_data : '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_q <= wr_data;
            end
        end

        assign image[g*PARCEL_W +: PARCEL_W] = slot_q;
    end

endmodule

// File: rtl/parcel_assembler.sv
module parcel_assembler
    import parcel_pkg::*;
#(
    parameter int PARCEL_W    = 16,
    parameter int MAX_PARCELS = 11
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            flush,
    input  logic                            in_valid,
    output logic                            in_ready,
    input  logic [PARCEL_W-1:0]             in_parcel,
    output logic                            out_valid,
    input  logic                            out_ready,
    output logic [PARCEL_W*MAX_PARCELS-1:0] out_instr,
    output logic [$clog2(MAX_PARCELS+1)-1:0] out_len,
    output logic                            out_rsvd
);

    localparam int INSTR_W = PARCEL_W * MAX_PARCELS;
    localparam int LEN_W   = $clog2(MAX_PARCELS + 1);

    asm_state_e        state_q, state_d;
    logic [LEN_W-1:0]  cnt_q, cnt_d;
    logic [LEN_W-1:0]  need_q, need_d;
    logic              rsvd_q, rsvd_d;

    logic [LEN_W-1:0]  dec_len;
    logic              dec_rsvd;
    logic              bank_start;
    logic              bank_wr;
    logic [INSTR_W-1:0] bank_image;

    parcel_len_decode #(
        .PARCEL_W (PARCEL_W),
        .LEN_W    (LEN_W)
    ) len_dec_i (
        .head (in_parcel),
        .len  (dec_len),
        .rsvd (dec_rsvd)
    );

    parcel_slot_bank #(
        .PARCEL_W (PARCEL_W),
        .SLOTS    (MAX_PARCELS),
        .IDX_W    (LEN_W)
    ) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (bank_start),
        .wr_en   (bank_wr),
        .wr_idx  (cnt_q),
        .wr_data (in_parcel),
        .image   (bank_image)
    );

    // Next-state and datapath control.
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        need_d     = need_q;
        rsvd_d     = rsvd_q;
        bank_start = 1'b0;
        bank_wr    = 1'b0;
        if (flush) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        bank_start = 1'b1;
                        need_d     = dec_len;
                        rsvd_d     = dec_rsvd;
                        cnt_d      = LEN_W'(1);
                        state_d    = (dec_len == LEN_W'(1)) ? ST_HOLD : ST_COLLECT;
                    end
                end
                ST_COLLECT: begin
                    if (in_valid) begin
                        bank_wr = 1'b1;
                        cnt_d   = cnt_q + LEN_W'(1);
                        if ((cnt_q + LEN_W'(1)) == need_q) begin
                            state_d = ST_HOLD;
                        end
                    end
                end
                ST_HOLD: begin
                    if (out_ready) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            need_q  <= LEN_W'(1);
            rsvd_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            need_q  <= need_d;
            rsvd_q  <= rsvd_d;
        end
    end

    // Outputs.
    always_comb begin
        in_ready  = (state_q != ST_HOLD) && !flush;
        out_valid = (state_q == ST_HOLD);
        out_instr = bank_image;
        out_len   = need_q;
        out_rsvd  = rsvd_q;
    end

endmodule

// File: rtl/parcel_assembler_chk.sv
module parcel_assembler_chk #(
    parameter int PARCEL_W    = 16,
    parameter int MAX_PARCELS = 11,
    parameter int LEN_W       = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            flush,
    input logic                            in_ready,
    input logic                            out_valid,
    input logic                            out_ready,
    input logic [PARCEL_W*MAX_PARCELS-1:0] out_instr,
    input logic [LEN_W-1:0]                out_len,
    input logic                            out_rsvd
);

    p_short_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_rsvd && out_len == LEN_W'(1)) |-> (out_instr[1:0] != 2'b11));

    p_pair_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_len == LEN_W'(2)) |-> (out_instr[1:0] == 2'b11 && out_instr[4:2] != 3'b111));

    p_len_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len >= LEN_W'(1) && out_len <= LEN_W'(MAX_PARCELS)));

    p_rsvd_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_rsvd) |-> (out_len == LEN_W'(1) && out_instr[14:12] == 3'b111));

    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_instr >> (int'(out_len) * PARCEL_W)) == '0));

    p_ready_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=>
            (out_valid && $stable(out_instr) && $stable(out_len) && $stable(out_rsvd)));

    p_flush_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

endmodule

bind parcel_assembler parcel_assembler_chk #(
    .PARCEL_W    (PARCEL_W),
    .MAX_PARCELS (MAX_PARCELS),
    .LEN_W       ($clog2(MAX_PARCELS + 1))
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_instr (out_instr),
    .out_len   (out_len),
    .out_rsvd  (out_rsvd)
);

// File: tb/parcel_assembler_tb_top.sv
module parcel_assembler_tb_top;

    localparam int NI = 300;
    localparam int NP_MAX = NI * 11;

    logic         clk = 1'b0;
    logic         rst_n, flush, in_valid, in_ready, out_valid, out_ready, out_rsvd;
    logic [15:0]  in_parcel;
    logic [175:0] out_instr;
    logic [3:0]   out_len;

    parcel_assembler dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in_valid(in_valid), .in_ready(in_ready), .in_parcel(in_parcel),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_instr(out_instr), .out_len(out_len), .out_rsvd(out_rsvd)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [15:0]  stream [NP_MAX];
    logic [175:0] exp_instr [NI];
    int           exp_len [NI];
    bit           exp_rsvd [NI];
    int           exp_kind [NI];
    string        tags [6] = '{"R1", "R2", "R3", "R4", "R5", "R6"};

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [175:0] act, input logic [175:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Length rule from the requirements; rsvd reports the reserved code.
    function automatic int len_ref(input logic [15:0] p, output bit rsvd);
        rsvd = 1'b0;
        if (p[1:0] != 2'b11) return 1;
        if (p[4:2] != 3'b111) return 2;
        if (p[6:0] == 7'b0011111 || p[6:0] == 7'b1011111) return 3;
        if (p[6:0] == 7'b0111111) return 4;
        if (p[14:12] != 3'b111) return 5 + int'(p[14:12]);
        rsvd = 1'b1;
        return 1;
    endfunction

    function automatic logic [15:0] make_head(input int kind);
        logic [15:0] p;
        p = 16'($urandom);
        case (kind)
            0: if (p[1:0] == 2'b11) p[1:0] = 2'($urandom_range(0, 2));
            1: begin p[1:0] = 2'b11; p[4:2] = 3'($urandom_range(0, 6)); end
            2: p[5:0] = 6'b011111;
            3: p[6:0] = 7'b0111111;
            4: begin p[6:0] = 7'h7F; p[14:12] = 3'($urandom_range(0, 6)); end
            default: begin p[6:0] = 7'h7F; p[14:12] = 3'b111; end
        endcase
        return p;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R8 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int np;
        int pidx;
        int oidx;
        bit hold_prev;
        logic [180:0] hold_val;
        int dir_kind [8] = '{5, 0, 4, 4, 2, 3, 1, 5};

        void'($urandom(32'd20240611));
        np = 0;
        for (int i = 0; i < NI; i++) begin
            logic [15:0] h;
            bit r;
            int k;
            k = (i < 8) ? dir_kind[i] : int'($urandom_range(0, 5));
            h = make_head(k);
            // Directed long cases: largest and smallest length field.
            if (i == 2) h[14:12] = 3'd6;
            if (i == 3) h[14:12] = 3'd0;
            exp_kind[i]  = k;
            exp_len[i]   = len_ref(h, r);
            exp_rsvd[i]  = r;
            exp_instr[i] = '0;
            for (int j = 0; j < exp_len[i]; j++) begin
                logic [15:0] w;
                w = (j == 0) ? h : 16'($urandom);
                stream[np] = w;
                exp_instr[i][j*16 +: 16] = w;
                np++;
            end
        end

        rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_parcel = '0;
        repeat (3) @(negedge clk);
        chk(!out_valid && in_ready, "R12", "reset state", {out_valid, in_ready}, 2'b01);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && in_ready, "R12", "after reset", {out_valid, in_ready}, 2'b01);

        // Random stream with gaps on both sides.
        pidx = 0; oidx = 0; hold_prev = 1'b0; hold_val = '0;
        while (oidx < NI) begin
            @(negedge clk);
            in_valid  = (pidx < np) && ($urandom_range(0, 3) != 0);
            in_parcel = (pidx < np) ? stream[pidx] : 16'hDEAD;
            out_ready = ($urandom_range(0, 2) != 0);
            #1;
            if (hold_prev) begin
                chk(out_valid && {out_rsvd, out_len, out_instr} == hold_val, "R10",
                    "held output", {out_rsvd, out_len, out_instr}, hold_val);
            end
            if (out_valid) chk(!in_ready, "R10", "in_ready while held", in_ready, 1'b0);
            hold_prev = out_valid && !out_ready;
            hold_val  = {out_rsvd, out_len, out_instr};
            if (out_valid && out_ready) begin
                chk(out_len == 4'(exp_len[oidx]) && out_rsvd == exp_rsvd[oidx],
                    tags[exp_kind[oidx]], "len/flag", {out_rsvd, out_len},
                    {exp_rsvd[oidx], 4'(exp_len[oidx])});
                chk(out_instr == exp_instr[oidx], "R7,R9", "instruction",
                    out_instr, exp_instr[oidx]);
                oidx++;
            end
            if (in_valid && in_ready) pidx++;
        end
        chk(pidx == np, "R8", "parcels consumed", pidx, np);

        // Flush in the middle of a six-parcel instruction.
        @(negedge clk);
        in_valid = 1'b1; out_ready = 1'b1; in_parcel = 16'h107F;
        @(negedge clk);
        in_parcel = 16'hAAAA;
        @(negedge clk);
        in_valid = 1'b0; flush = 1'b1;
        #1;
        chk(!in_ready, "R11", "in_ready during flush", in_ready, 1'b0);
        @(negedge clk);
        flush = 1'b0;
        #1;
        chk(!out_valid && in_ready, "R11", "state after flush", {out_valid, in_ready}, 2'b01);
        @(negedge clk);
        in_valid = 1'b1; in_parcel = 16'h1234; out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk(out_valid && out_len == 4'd1 && !out_rsvd, "R11", "first after flush",
            {out_valid, out_rsvd, out_len}, {1'b1, 1'b0, 4'd1});
        chk(out_instr == 176'h1234, "R11", "no stale parcels", out_instr, 176'h1234);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule